// File: doc/BRIEF.md
# Maintenance Clock Source Selector

This block decides which timing source drives the processor's clock-enable. It has three sources. The first is the free-running main clock, which enables every cycle. The second is an adjustable diagnostic oscillator. It is modelled as a single-cycle tick input, so it can be run slower or faster than normal to test timing margins. The third is a manual single-step switch. The switch is synchronized to the main clock and edge-detected, so each press gives exactly one enable pulse.

The two maintenance sources can only be used while a maintenance-enable flip-flop is set. That flip-flop follows two mode switches. It is set only while both switches read 1, and it drops as soon as either switch reads 0. When the flip-flop is clear, the block runs from the main clock whatever the source-select input says. A change of source is applied between enable pulses, with one blank cycle, so pulses from the old and new source never merge.

Top module: `step_clock_select`

## Requirements
- R1: During reset `cpu_ce` and `maint_en` are 0 and the main source is selected. In the first cycle after reset is released, `cpu_ce` is 1.
- R2: `maint_en` becomes 1 one clock after both maintenance switches are sampled at 1. It becomes 0 one clock after either switch is sampled at 0.
- R3: While the main source is active, `cpu_ce` is 1 in every cycle.
- R4: `src_sel` encoding: 2'b00 selects the main clock, 2'b01 the diagnostic tick and 2'b10 the step switch. 2'b11 selects the main clock.
- R5: While the diagnostic source is active, each `diag_tick` cycle gives exactly one `cpu_ce` pulse, in the following cycle. Ticks have no effect under any other source.
- R6: While the step source is active, each rising edge of `step_sw` gives exactly one single-cycle `cpu_ce` pulse, three clocks after the rise, however long the switch is held.
- R7: While `maint_en` is 0, the main source is used for every `src_sel` value, and `step_sw` and `diag_tick` have no effect.
- R8: When the requested source differs from the active one, `cpu_ce` is 0 for exactly one cycle. The new source then drives `cpu_ce` from the next cycle on.
- R9: A `step_sw` edge that occurs while the step source is not active is discarded. It does not produce a pulse after the step source becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main free-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| diag_tick | input | 1 | Diagnostic oscillator tick, one cycle wide, synchronous to `clk` |
| step_sw | input | 1 | Manual single-step switch level, asynchronous |
| maint_sw_a | input | 1 | First maintenance mode switch |
| maint_sw_b | input | 1 | Second maintenance mode switch |
| src_sel | input | 2 | Requested timing source (see R4) |
| cpu_ce | output | 1 | Processor clock-enable pulse stream |
| maint_en | output | 1 | Maintenance-enable flip-flop state |

## Verification
A vector table walks every combination of switch pair and `src_sel`. Each entry counts enable pulses over a fixed window while ticks and step presses are applied together. The count separates three cases: a source that follows its own stimulus, a source that ignores a foreign stimulus, and a fall back to the main clock, which gives a full-window count. Directed sequences then pin down exact latencies: the three-clock step delay with a long hold, the one-cycle blank on each source change, and the one-clock response of the maintenance flip-flop. A last sequence presses the step switch while another source is active and checks that the press does not appear later.

// File: rtl/scs_pkg.sv
package scs_pkg;

    typedef enum logic [1:0] {
        SRC_MAIN = 2'b00,
        SRC_DIAG = 2'b01,
        SRC_STEP = 2'b10
    } src_e;

    // Map the raw select code onto a source; the unused code falls back to main.
    function automatic src_e decode_sel(input logic [1:0] sel);
        case (sel)
            2'b01:   return SRC_DIAG;
            2'b10:   return SRC_STEP;
            default: return SRC_MAIN;
        endcase
    endfunction

endpackage

// File: rtl/scs_step_detect.sv
module scs_step_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_async,
    output logic rise
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], sw_async};
        st_d.prev = st_q.sync[LAST];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.sync[LAST] & ~st_q.prev;

    // R6: a single press never yields two adjacent edges
    p_single_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/scs_maint_latch.sv
module scs_maint_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_a,
    input  logic sw_b,
    output logic enable
);
    logic en_d, en_q;

    always_comb begin
        en_d = sw_a & sw_b;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign enable = en_q;

    p_set_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_a && sw_b) |=> enable);
    p_clear_any_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_a && sw_b) |=> !enable);

endmodule

// File: rtl/step_clock_select.sv
module step_clock_select
    import scs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       diag_tick,
    input  logic       step_sw,
    input  logic       maint_sw_a,
    input  logic       maint_sw_b,
    input  logic [1:0] src_sel,
    output logic       cpu_ce,
    output logic       maint_en
);
    typedef struct packed {
        src_e active;
        logic ce;
    } mux_t;

    mux_t st_d, st_q;
    logic step_rise;
    logic maint_q;
    src_e req;

    scs_step_detect #(.SYNC_STAGES(SYNC_STAGES)) i_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_async (step_sw),
        .rise     (step_rise)
    );

    scs_maint_latch i_maint (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_a   (maint_sw_a),
        .sw_b   (maint_sw_b),
        .enable (maint_q)
    );

    always_comb begin
        req    = maint_q ? decode_sel(src_sel) : SRC_MAIN;
        st_d   = st_q;
        st_d.active = req;
        if (req != st_q.active) begin
            st_d.ce = 1'b0;                 // blank cycle at handover
        end else begin
            case (st_q.active)
                SRC_DIAG: st_d.ce = diag_tick;
                SRC_STEP: st_d.ce = step_rise;
                default:  st_d.ce = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.active <= SRC_MAIN;
            st_q.ce     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_ce   = st_q.ce;
    assign maint_en = maint_q;

    p_handover_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req != st_q.active) |=> !cpu_ce);
    p_no_maint_main_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !maint_q |=> (st_q.active == SRC_MAIN));
    p_step_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active == SRC_STEP && !step_rise) |=> !cpu_ce);
    p_diag_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active == SRC_DIAG && !diag_tick) |=> !cpu_ce);

endmodule

// File: tb/test_step_clock_select.sv
`timescale 1ns/1ps
module test_step_clock_select;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       diag_tick = 1'b0;
    logic       step_sw = 1'b0;
    logic       maint_sw_a = 1'b0;
    logic       maint_sw_b = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic       cpu_ce;
    logic       maint_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    step_clock_select i_step_clock_select (
        .clk(clk), .rst_n(rst_n), .diag_tick(diag_tick), .step_sw(step_sw),
        .maint_sw_a(maint_sw_a), .maint_sw_b(maint_sw_b), .src_sel(src_sel),
        .cpu_ce(cpu_ce), .maint_en(maint_en)
    );

    // {sw_a, sw_b, sel[1:0], ticks[3:0], steps[3:0], expected pulses[7:0]}
    localparam logic [19:0] VEC [9] = '{
        {1'b0, 1'b0, 2'b00, 4'd4, 4'd2, 8'd64},  // R3 main
        {1'b1, 1'b1, 2'b01, 4'd6, 4'd2, 8'd6 },  // R5 diag, steps ignored
        {1'b1, 1'b1, 2'b10, 4'd5, 4'd3, 8'd3 },  // R6 step, ticks ignored
        {1'b1, 1'b1, 2'b11, 4'd5, 4'd3, 8'd64},  // R4 code 11 is main
        {1'b1, 1'b0, 2'b10, 4'd0, 4'd3, 8'd64},  // R7 one switch off
        {1'b0, 1'b1, 2'b01, 4'd5, 4'd0, 8'd64},  // R7 other switch off
        {1'b1, 1'b1, 2'b10, 4'd9, 4'd0, 8'd0 },  // R5 ticks no effect in step
        {1'b1, 1'b1, 2'b01, 4'd0, 4'd4, 8'd0 },  // R5 no ticks, no pulses
        {1'b1, 1'b1, 2'b00, 4'd7, 4'd4, 8'd64}   // R4 code 00 is main
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        // R1 reset state
        cyc(3);
        chk("R1 ce in reset", int'(cpu_ce), 0);
        chk("R1 maint_en in reset", int'(maint_en), 0);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 ce first cycle after reset", int'(cpu_ce), 1);

        // Vector table
        foreach (VEC[v]) begin
            maint_sw_a = VEC[v][19];
            maint_sw_b = VEC[v][18];
            src_sel    = VEC[v][17:16];
            diag_tick  = 1'b0;
            step_sw    = 1'b0;
            cyc(8);
            cnt = 0;
            for (int c = 0; c < 64; c++) begin
                diag_tick = (c % 5 == 0) && (c / 5 < int'(VEC[v][15:12]));
                step_sw   = (c % 12 < 6) && (c / 12 < int'(VEC[v][11:8]));
                @(negedge clk);
                cnt += int'(cpu_ce);
            end
            diag_tick = 1'b0;
            step_sw   = 1'b0;
            chk($sformatf("R3/R4/R5/R6/R7 vector %0d pulse count", v), cnt, int'(VEC[v][7:0]));
        end

        // R2 flip-flop timing
        maint_sw_a = 1'b0; maint_sw_b = 1'b0; src_sel = 2'b00;
        cyc(3);
        maint_sw_a = 1'b1; maint_sw_b = 1'b1;
        cyc(1);
        chk("R2 set after one clock", int'(maint_en), 1);
        maint_sw_a = 1'b0;
        cyc(1);
        chk("R2 clear after one clock", int'(maint_en), 0);
        maint_sw_a = 1'b1;
        cyc(1);
        chk("R2 set again", int'(maint_en), 1);

        // R8 handover blank cycle: main -> diag with tick held
        cyc(3);
        diag_tick = 1'b1;
        src_sel = 2'b01;
        cyc(1);
        chk("R8 blank cycle main to diag", int'(cpu_ce), 0);
        cyc(1);
        chk("R8 diag drives after blank", int'(cpu_ce), 1);
        diag_tick = 1'b0;
        cyc(1);
        chk("R5 tick pulse is one cycle", int'(cpu_ce), 0);
        src_sel = 2'b00;
        cyc(1);
        chk("R8 blank cycle diag to main", int'(cpu_ce), 0);
        cyc(1);
        chk("R8 main drives after blank", int'(cpu_ce), 1);

        // R6 latency with long hold
        src_sel = 2'b10;
        cyc(6);
        step_sw = 1'b1;
        cyc(2);
        chk("R6 no pulse before third clock", int'(cpu_ce), 0);
        cyc(1);
        chk("R6 pulse on third clock", int'(cpu_ce), 1);
        cnt = 0;
        for (int i = 0; i < 10; i++) begin @(negedge clk); cnt += int'(cpu_ce); end
        chk("R6 long hold gives no more pulses", cnt, 0);
        step_sw = 1'b0;
        cyc(6);

        // R9 edge outside step mode is discarded
        src_sel = 2'b00;
        cyc(4);
        step_sw = 1'b1;
        cyc(6);
        src_sel = 2'b10;
        cnt = 0;
        for (int i = 0; i < 12; i++) begin @(negedge clk); cnt += int'(cpu_ce); end
        chk("R9 earlier edge not replayed", cnt, 0);
        step_sw = 1'b0;
        cyc(4);
        step_sw = 1'b1;
        cnt = 0;
        for (int i = 0; i < 8; i++) begin @(negedge clk); cnt += int'(cpu_ce); end
        chk("R9 fresh edge still works", cnt, 1);
        step_sw = 1'b0;
        cyc(4);

        // R7 losing a switch while stepping falls back to main
        maint_sw_b = 1'b0;
        cyc(1);
        chk("R7 maint_en drops", int'(maint_en), 0);
        cyc(1);
        chk("R7 blank on forced handover", int'(cpu_ce), 0);
        cyc(1);
        chk("R7 main clock resumes", int'(cpu_ce), 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule